// File: doc/BRIEF.md
# Pixel Transfer Packer with Rectangle Walker

This block sits between a 32-bit host word stream and the pixel port of a colour or depth buffer. A transfer is armed with a single start pulse. That pulse sets the direction (host to buffer, or buffer to host), the packed pixel size, the rectangle origin and extent, and the traversal order on each axis. The block then steps through the rectangle and presents one buffer address per clock.

In the write direction, each host word is split into pixels, lowest field first. One 32-bit pixel leaves per clock. For 1-bit data there is an optional colour expansion, which replaces each bit with one of two 32-bit RGBA values. In the read direction, the pixels returned by the buffer are gathered into host words in the same field order. A last word that is only partly filled is sent out with zeros in its unused fields.

A depth-to-colour copy flag fixes the walk to its forward order on both axes. A one-cycle done pulse closes each transfer. Rectangle width and height must both be at least one.

Top module: `pix_dma_packer`

## Requirements
- R1: While and after reset, `px_valid_o`, `hout_valid_o` and `done_o` are low, and `hin_ready_o` is low until a transfer is started.
- R2: In the write direction, `pix_size_i` selects pixels per word: 0 gives one 32-bit pixel, 1 gives two 16-bit, 2 gives four 8-bit and 3 gives thirty-two 1-bit. Pixel n of a word is bits [n*size +: size]. It is emitted zero-extended to 32 bits on `px_data_o`, with field 0 first.
- R3: With `expand_i` high and size code 3, a 0 bit is emitted as `color_a_i` and a 1 bit as `color_b_i`. With any other size code, `expand_i` has no effect.
- R4: A host word is taken only in a cycle where the previous word has no pixel left to emit. Once the first pixel appears, pixels leave on consecutive clocks with no gap until the last one, in both directions.
- R5: With `x_rev_i` low, each row runs from `rect_x_i` upward to `rect_x_i+rect_w_i-1`. With `x_rev_i` high, it runs from `rect_x_i+rect_w_i-1` downward.
- R6: With `y_up_i` low, rows run from `rect_y_i` with the row number rising. With `y_up_i` high, they run from `rect_y_i+rect_h_i-1` with the row number falling. After the last column of a row, the walk moves to the first column of the next row.
- R7: With `zcopy_i` high, both axes use forward order whatever the values of `x_rev_i` and `y_up_i`.
- R8: In the read direction, returned pixel k is placed in word k/P, field k%P. Only its low size bits are kept. A partly filled last word is output with its unused fields zero.
- R9: `done_o` is high for exactly one cycle. In the write direction it rises with the last pixel. In the read direction it rises with the last host word.
- R10: In the write direction, exactly ceil(W*H/P) host words are taken. Fields of the last word beyond the last pixel are dropped, and `hin_ready_o` stays low once the last pixel has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| write_i | input | 1 | 1: host to buffer, 0: buffer to host |
| pix_size_i | input | 2 | Packed pixel size code (0:32, 1:16, 2:8, 3:1) |
| expand_i | input | 1 | Two-colour expansion for 1-bit pixels |
| color_a_i | input | 32 | Colour used for a 0 bit |
| color_b_i | input | 32 | Colour used for a 1 bit |
| x_rev_i | input | 1 | Right-to-left walk |
| y_up_i | input | 1 | Bottom-to-top walk |
| zcopy_i | input | 1 | Depth-to-colour copy, forces forward walk |
| rect_x_i | input | CW | Rectangle left column |
| rect_y_i | input | CW | Rectangle top row |
| rect_w_i | input | CW | Rectangle width (>=1) |
| rect_h_i | input | CW | Rectangle height (>=1) |
| hin_valid_i | input | 1 | Host word valid |
| hin_data_i | input | 32 | Host word |
| hin_ready_o | output | 1 | Host word taken this cycle when valid |
| px_valid_o | output | 1 | Pixel address (and write data) valid |
| px_x_o | output | CW | Pixel column |
| px_y_o | output | CW | Pixel row |
| px_data_o | output | 32 | Pixel written to the buffer |
| rd_valid_i | input | 1 | Pixel returned by the buffer |
| rd_data_i | input | 32 | Returned pixel value |
| hout_valid_o | output | 1 | Packed host word valid |
| hout_data_o | output | 32 | Packed host word |
| done_o | output | 1 | End-of-transfer pulse |

## Verification
The bench covers a grid of configurations: all four pixel sizes, widths of 1, 3 and 5, heights of 1 to 3, all four axis orders, and the copy flag both on and off, in both directions. Widths of 1 and heights of 1 isolate the row wrap from the column step. Rectangles whose pixel count is not a multiple of the fields per word exercise the dropped write fields and the zero-padded read word.

Host words and returned pixels are hashed from their index or coordinates, so any swapped field, wrong lane or misordered address shows up as a value mismatch. Running expansion with the 32, 16 and 8-bit sizes shows that the expand flag is ignored outside 1-bit mode. Timing the gap between the first pixel and `done_o` separates a stalling unpacker from one that runs back to back.

// File: rtl/pixdma_pkg.sv
package pixdma_pkg;
  typedef enum logic [1:0] {
    PS_32 = 2'd0,
    PS_16 = 2'd1,
    PS_8  = 2'd2,
    PS_1  = 2'd3
  } pix_size_e;

  // last field index within a 32-bit host word
  function automatic logic [4:0] last_lane(pix_size_e s);
    case (s)
      PS_32:   return 5'd0;
      PS_16:   return 5'd1;
      PS_8:    return 5'd3;
      default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/pixdma_walker.sv
module pixdma_walker #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] x0,
  input  logic [CW-1:0] y0,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  input  logic          xrev,
  input  logic          yup,
  output logic [CW-1:0] cur_x,
  output logic [CW-1:0] cur_y,
  output logic          last
);
  logic [CW-1:0] col, row, w_l, h_l, sx;
  logic          xr_l, yu_l;

  assign last = (col == w_l - 1'b1) && (row == h_l - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0; row <= '0; w_l <= '0; h_l <= '0; sx <= '0;
      cur_x <= '0; cur_y <= '0; xr_l <= 1'b0; yu_l <= 1'b0;
    end else if (load) begin
      col  <= '0;
      row  <= '0;
      w_l  <= w;
      h_l  <= h;
      xr_l <= xrev;
      yu_l <= yup;
      sx    <= xrev ? x0 + w - 1'b1 : x0;
      cur_x <= xrev ? x0 + w - 1'b1 : x0;
      cur_y <= yup  ? y0 + h - 1'b1 : y0;
    end else if (step) begin
      if (col == w_l - 1'b1) begin
        col   <= '0;
        row   <= row + 1'b1;
        cur_x <= sx;
        cur_y <= yu_l ? cur_y - 1'b1 : cur_y + 1'b1;
      end else begin
        col   <= col + 1'b1;
        cur_x <= xr_l ? cur_x - 1'b1 : cur_x + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixdma_unpack.sv
module pixdma_unpack
  import pixdma_pkg::*;
(
  input  logic [31:0] word,
  input  pix_size_e   size,
  input  logic [4:0]  lane,
  input  logic        expand,
  input  logic [31:0] col_a,
  input  logic [31:0] col_b,
  output logic [31:0] pix
);
  logic bitv;
  assign bitv = word[lane];

  always_comb begin
    case (size)
      PS_32:   pix = word;
      PS_16:   pix = lane[0] ? {16'h0, word[31:16]} : {16'h0, word[15:0]};
      PS_8:    pix = {24'h0, word[8*lane[1:0] +: 8]};
      default: pix = expand ? (bitv ? col_b : col_a) : {31'h0, bitv};
    endcase
  end
endmodule

// File: rtl/pixdma_pack.sv
module pixdma_pack
  import pixdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  pix_size_e   size,
  input  logic        pix_valid,
  input  logic [31:0] pix,
  input  logic        final_pix,
  output logic        word_valid,
  output logic [31:0] word,
  output logic        word_last
);
  logic [31:0] acc, acc_n, field;
  logic [4:0]  lane;

  always_comb begin
    case (size)
      PS_32:   field = pix;
      PS_16:   field = {16'h0, pix[15:0]} << (16 * lane[0]);
      PS_8:    field = {24'h0, pix[7:0]} << (8 * lane[1:0]);
      default: field = {31'h0, pix[0]} << lane;
    endcase
    acc_n = acc | field;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; lane <= '0; word_valid <= 1'b0; word <= '0; word_last <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      word_last  <= 1'b0;
      if (clear) begin
        acc  <= '0;
        lane <= '0;
      end else if (pix_valid) begin
        if (lane == last_lane(size) || final_pix) begin
          word       <= acc_n;
          word_valid <= 1'b1;
          word_last  <= final_pix;
          acc        <= '0;
          lane       <= '0;
        end else begin
          acc  <= acc_n;
          lane <= lane + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pix_dma_packer.sv
module pix_dma_packer
  import pixdma_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [1:0]    pix_size_i,
  input  logic          expand_i,
  input  logic [31:0]   color_a_i,
  input  logic [31:0]   color_b_i,
  input  logic          x_rev_i,
  input  logic          y_up_i,
  input  logic          zcopy_i,
  input  logic [CW-1:0] rect_x_i,
  input  logic [CW-1:0] rect_y_i,
  input  logic [CW-1:0] rect_w_i,
  input  logic [CW-1:0] rect_h_i,
  input  logic          hin_valid_i,
  input  logic [31:0]   hin_data_i,
  output logic          hin_ready_o,
  output logic          px_valid_o,
  output logic [CW-1:0] px_x_o,
  output logic [CW-1:0] px_y_o,
  output logic [31:0]   px_data_o,
  input  logic          rd_valid_i,
  input  logic [31:0]   rd_data_i,
  output logic          hout_valid_o,
  output logic [31:0]   hout_data_o,
  output logic          done_o
);
  localparam int TW = 2 * CW;

  logic          busy, wr_l, exp_l, fin, have_word, done_q, pk_last;
  pix_size_e     size_l;
  logic [31:0]   ca, cb, word_r, unp;
  logic [4:0]    lane_r;
  logic [TW-1:0] total, rd_cnt;
  logic [CW-1:0] cur_x, cur_y;
  logic          w_last, start_ok, emit, issue, accept, lane_end, rd_take, rd_final;

  assign start_ok    = start_i && !busy;
  assign emit        = busy && wr_l && have_word && !fin;
  assign issue       = busy && !wr_l && !fin;
  assign lane_end    = (lane_r == last_lane(size_l)) || w_last;
  assign hin_ready_o = busy && wr_l && !fin &&
                       (!have_word || (emit && lane_r == last_lane(size_l) && !w_last));
  assign accept      = hin_valid_i && hin_ready_o;
  assign rd_take     = busy && !wr_l && rd_valid_i;
  assign rd_final    = rd_take && (rd_cnt == total - 1'b1);
  assign done_o      = done_q || pk_last;

  pixdma_walker #(.CW(CW)) u_walk (
    .clk(clk), .rst(rst), .load(start_ok), .step(emit || issue),
    .x0(rect_x_i), .y0(rect_y_i), .w(rect_w_i), .h(rect_h_i),
    .xrev(x_rev_i && !zcopy_i), .yup(y_up_i && !zcopy_i),
    .cur_x(cur_x), .cur_y(cur_y), .last(w_last)
  );

  pixdma_unpack u_unp (
    .word(word_r), .size(size_l), .lane(lane_r), .expand(exp_l),
    .col_a(ca), .col_b(cb), .pix(unp)
  );

  pixdma_pack u_pack (
    .clk(clk), .rst(rst), .clear(start_ok), .size(size_l),
    .pix_valid(rd_take), .pix(rd_data_i), .final_pix(rd_final),
    .word_valid(hout_valid_o), .word(hout_data_o), .word_last(pk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; wr_l <= 1'b0; exp_l <= 1'b0; fin <= 1'b0; have_word <= 1'b0;
      done_q <= 1'b0; size_l <= PS_32; ca <= '0; cb <= '0; word_r <= '0;
      lane_r <= '0; total <= '0; rd_cnt <= '0;
      px_valid_o <= 1'b0; px_x_o <= '0; px_y_o <= '0; px_data_o <= '0;
    end else begin
      done_q     <= 1'b0;
      px_valid_o <= 1'b0;
      if (start_ok) begin
        busy      <= 1'b1;
        wr_l      <= write_i;
        exp_l     <= expand_i;
        size_l    <= pix_size_e'(pix_size_i);
        ca        <= color_a_i;
        cb        <= color_b_i;
        fin       <= 1'b0;
        have_word <= 1'b0;
        lane_r    <= '0;
        rd_cnt    <= '0;
        total     <= TW'(rect_w_i) * TW'(rect_h_i);
      end
      if (emit) begin
        px_valid_o <= 1'b1;
        px_data_o  <= unp;
        px_x_o     <= cur_x;
        px_y_o     <= cur_y;
        lane_r     <= lane_r + 1'b1;
        if (lane_end) have_word <= 1'b0;
        if (w_last) begin
          fin    <= 1'b1;
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (accept) begin
        word_r    <= hin_data_i;
        have_word <= 1'b1;
        lane_r    <= '0;
      end
      if (issue) begin
        px_valid_o <= 1'b1;
        px_data_o  <= '0;
        px_x_o     <= cur_x;
        px_y_o     <= cur_y;
        if (w_last) fin <= 1'b1;
      end
      if (rd_take) begin
        rd_cnt <= rd_cnt + 1'b1;
        if (rd_final) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pix_dma_packer_chk.sv
module pix_dma_packer_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          wr_l,
  input logic          hin_ready,
  input logic          px_valid,
  input logic [CW-1:0] px_x,
  input logic [CW-1:0] px_y,
  input logic          hout_valid,
  input logic          done
);
  p_ready_needs_busy_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !hin_ready);

  p_done_with_beat_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (px_valid || hout_valid));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_xstep_r5: assert property (@(posedge clk) disable iff (rst)
    (px_valid && $past(px_valid) && px_y == $past(px_y)) |->
      (px_x == $past(px_x) + 1'b1 || px_x == $past(px_x) - 1'b1));

  p_ystep_r6: assert property (@(posedge clk) disable iff (rst)
    (px_valid && $past(px_valid) && px_y != $past(px_y)) |->
      (px_y == $past(px_y) + 1'b1 || px_y == $past(px_y) - 1'b1));

  p_no_word_out_in_write_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_l) |-> !hout_valid);
endmodule

bind pix_dma_packer pix_dma_packer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .wr_l(wr_l), .hin_ready(hin_ready_o),
  .px_valid(px_valid_o), .px_x(px_x_o), .px_y(px_y_o),
  .hout_valid(hout_valid_o), .done(done_o)
);

// File: tb/sim_pix_dma_packer.sv
`timescale 1ns/1ps
module sim_pix_dma_packer;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start_i = 0, write_i = 0, expand_i = 0, x_rev_i = 0, y_up_i = 0, zcopy_i = 0;
  logic [1:0]    pix_size_i = 0;
  logic [31:0]   color_a_i = 32'hA1B2C3D4, color_b_i = 32'h0F1E2D3C;
  logic [CW-1:0] rect_x_i = 12'd10, rect_y_i = 12'd20, rect_w_i = 12'd1, rect_h_i = 12'd1;
  logic          hin_valid_i = 0, rd_valid_i = 0;
  logic [31:0]   hin_data_i = 0, rd_data_i = 0;
  logic          hin_ready_o, px_valid_o, hout_valid_o, done_o;
  logic [CW-1:0] px_x_o, px_y_o;
  logic [31:0]   px_data_o, hout_data_o;

  pix_dma_packer #(.CW(CW)) u0 (.*);

  int checks = 0, errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  int c_sz, c_w, c_h, c_xr, c_yu, c_seed;

  function automatic int ppw(int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 32;
  endfunction
  function automatic int bpp(int s);
    return (s == 0) ? 32 : (s == 1) ? 16 : (s == 2) ? 8 : 1;
  endfunction
  function automatic logic [31:0] gen(int i);
    return (32'h9E3779B9 * (i + 1 + c_seed)) ^ (32'(i) << 11) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] mem(int x, int y);
    logic [7:0] xb, yb;
    xb = 8'(x); yb = 8'(y);
    return {8'hC3 ^ yb, yb, xb + yb * 8'd5, xb ^ (yb << 1) ^ 8'h5A};
  endfunction
  function automatic int ex_x(int k);
    int col = k % c_w;
    return c_xr ? 10 + c_w - 1 - col : 10 + col;
  endfunction
  function automatic int ex_y(int k);
    int row = k / c_w;
    return c_yu ? 20 + c_h - 1 - row : 20 + row;
  endfunction
  function automatic logic [31:0] field(logic [31:0] v, int s);
    return (s == 0) ? v : (s == 1) ? {16'h0, v[15:0]} : (s == 2) ? {24'h0, v[7:0]} : {31'h0, v[0]};
  endfunction

  task automatic run(input int sz, input bit wr, input bit ex, input int w, input int h,
                     input bit xr, input bit yu, input bit zc);
    int total, p, k, widx, j, first, guard;
    bit seen_done;
    logic [31:0] e, wd;
    total = w * h; p = ppw(sz);
    c_sz = sz; c_w = w; c_h = h; c_seed++;
    c_xr = (xr && !zc); c_yu = (yu && !zc);
    @(negedge clk);
    start_i = 1; write_i = wr; pix_size_i = 2'(sz); expand_i = ex;
    x_rev_i = xr; y_up_i = yu; zcopy_i = zc;
    rect_w_i = CW'(w); rect_h_i = CW'(h);
    @(posedge clk); #1;
    start_i = 0;
    k = 0; widx = 0; j = 0; first = -1; seen_done = 0; guard = 0;
    hin_valid_i = wr; hin_data_i = gen(0);
    while (!seen_done) begin
      bit acc;
      @(negedge clk);
      guard++;
      if (guard > 400) begin
        chk(0, "R9 watchdog", 32'(guard), 32'd400);
        break;
      end
      acc = wr && hin_ready_o;
      rd_valid_i = 0;
      if (px_valid_o) begin
        if (first < 0) first = int'(cyc);
        chk(px_x_o == CW'(ex_x(k)), "R5/R7 column", 32'(px_x_o), 32'(ex_x(k)));
        chk(px_y_o == CW'(ex_y(k)), "R6/R7 row", 32'(px_y_o), 32'(ex_y(k)));
        if (wr) begin
          wd = gen(k / p);
          e = field(wd >> ((k % p) * bpp(sz)), sz);
          if (sz == 3 && ex) e = e[0] ? color_b_i : color_a_i;
          chk(px_data_o == e, ex ? "R3 expand pixel" : "R2 unpacked pixel", px_data_o, e);
        end else begin
          rd_valid_i = 1; rd_data_i = mem(int'(px_x_o), int'(px_y_o));
        end
        k++;
      end
      if (hout_valid_o) begin
        e = 0;
        for (int l = 0; l < p; l++) begin
          int kk = j * p + l;
          if (kk < total) e = e | (field(mem(ex_x(kk), ex_y(kk)), sz) << (l * bpp(sz)));
        end
        chk(hout_data_o == e, "R8 packed word", hout_data_o, e);
        j++;
      end
      if (done_o) begin
        seen_done = 1;
        if (wr) begin
          chk(k == total, "R9 done with last pixel", 32'(k), 32'(total));
          chk(int'(cyc) - first == total - 1, "R4 back-to-back pixels", 32'(int'(cyc) - first), 32'(total - 1));
        end else begin
          chk(j == (total + p - 1) / p, "R9 done with last word", 32'(j), 32'((total + p - 1) / p));
          chk(k == total, "R4 read address count", 32'(k), 32'(total));
        end
      end
      @(posedge clk); #1;
      if (acc) begin
        widx++;
        hin_data_i = gen(widx);
      end
    end
    hin_valid_i = wr;
    rd_valid_i = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!px_valid_o && !hout_valid_o && !done_o, "R9 single done, idle after", {29'd0, px_valid_o, hout_valid_o, done_o}, 32'd0);
      chk(!hin_ready_o, "R10 no word after last pixel", 32'(hin_ready_o), 32'd0);
      @(posedge clk); #1;
    end
    if (wr) chk(widx == (total + p - 1) / p, "R10 host words taken", 32'(widx), 32'((total + p - 1) / p));
    hin_valid_i = 0;
  endtask

  initial begin
    int ws[3] = '{1, 3, 5};
    c_seed = 0;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!px_valid_o && !hout_valid_o && !done_o && !hin_ready_o, "R1 reset state",
        {28'd0, px_valid_o, hout_valid_o, done_o, hin_ready_o}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk(!px_valid_o && !hout_valid_o && !done_o && !hin_ready_o, "R1 idle after reset",
        {28'd0, px_valid_o, hout_valid_o, done_o, hin_ready_o}, 32'd0);
    for (int sz = 0; sz < 4; sz++)
      for (int wr = 0; wr < 2; wr++)
        for (int ex = 0; ex <= wr; ex++)
          for (int wi = 0; wi < 3; wi++)
            for (int h = 1; h <= 3; h++)
              for (int d = 0; d < 4; d++)
                for (int zc = 0; zc < 2; zc++)
                  run(sz, wr[0], ex[0], ws[wi], h, d[0], d[1], zc[0]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule